// File: doc/BRIEF.md
# Prioritized Device Interrupt Arbiter

This block decides, once per instruction, whether a processor must be diverted to an interrupt service routine. Each of several I/O devices owns a small status word holding a ready flag and an interrupt-enable flag. Software reads and writes these words through a simple register port. The device side raises the ready flag with a one-cycle pulse. A device is pending when both of its flags are set.

Every device also drives a fixed 3-bit urgency level and an 8-bit service vector. A keyboard, for example, would supply vector 0x80. Among the pending devices, a priority encoder picks the one with the highest level; ties go to the lowest device index. The winner's level is then compared with the 3-bit level of the running program. The interrupt is taken only when the winner is strictly more urgent. An equal level is not enough.

The processor pulses a sample strobe at the instruction boundary, after the result of one instruction is stored and before the next fetch. Only on that strobe does the block register the decision, the vector and the level. The outputs then hold until the next strobe.

Top module: `irq_arb`

## Requirements
- R1: After reset, every status word reads 0, and irqOut, irqVec and irqPrio are 0.
- R2: A write to address i (i < NUM_DEV) stores regWrData bit 15 as the ready flag and bit 14 as the enable flag. A read of address i returns ready at bit 15, enable at bit 14, and 0 in all other bits. Reads are combinational.
- R3: A pulse on devReadyPulse[i] sets the ready flag of device i at the next clock edge. When a software write to the same device happens in the same cycle, the ready flag still ends up set.
- R4: A device is pending only when both its ready flag and its enable flag are 1. With no device pending, a strobe yields irqOut = 0.
- R5: Among pending devices, the one with the largest devPrio field wins. On equal fields the lowest index wins. Device i's level is devPrio[3i+2:3i] and its vector is devVec[8i+7:8i].
- R6: On a strobe, irqOut becomes 1 only if the winner's level is strictly greater than cpuPrio. An equal level gives irqOut = 0.
- R7: irqOut, irqVec and irqPrio change only at a clock edge where sampleStb is 1, with the new values visible after that edge. Between strobes they hold, whatever the other inputs do.
- R8: When a strobe yields irqOut = 1, irqVec and irqPrio carry the winner's vector and level. When a strobe yields irqOut = 0, both are 0.
- R9: A write to an address at or above NUM_DEV changes no status word, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Software write enable for the status port |
| regAddr | input | ADDR_W | Status word address (device index) |
| regWrData | input | 16 | Software write data |
| regRdData | output | 16 | Status word read data |
| devReadyPulse | input | NUM_DEV | Per-device ready set pulse |
| devPrio | input | NUM_DEV*3 | Per-device fixed urgency levels, packed |
| devVec | input | NUM_DEV*8 | Per-device service vectors, packed |
| cpuPrio | input | 3 | Level of the running program |
| sampleStb | input | 1 | Instruction-boundary sample strobe |
| irqOut | output | 1 | Interrupt taken |
| irqVec | output | 8 | Vector of the accepted device |
| irqPrio | output | 3 | Level of the accepted device |

## Verification
The hardest cases to reach from the ports are those where two pending devices share the top level and that level equals cpuPrio. The tie rule and the strict comparison then both decide the result in the same strobe. To reach them, the bench sweeps all 256 combinations of ready and enable flags across four devices. For each combination it tries all eight program levels, under two level assignments that each contain duplicated levels. Separate directed steps cover a ready pulse that collides with a clearing write, and outputs that must hold while flags and cpuPrio change between strobes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int STAT_W    = 16;
  localparam int READY_POS = 15;
  localparam int EN_POS    = 14;
  localparam int PRIO_W    = 3;
  localparam int VEC_W     = 8;

  typedef struct packed {
    logic capture;  // register the arbitration result
    logic write;    // software write to an existing status word
  } ctlStrobes_t;
endpackage

// File: rtl/irq_arb_ctl.sv
module irq_arb_ctl
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 3
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sampleStb,
  output ctlStrobes_t       ctl
);
  logic addrInRange;

  always_comb begin
    addrInRange = (int'(regAddr) < NUM_DEV);
    ctl.write   = regWrEn && addrInRange;
    ctl.capture = sampleStb;
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               ctl,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [STAT_W-1:0]         regWrData,
  output logic [STAT_W-1:0]         regRdData,
  input  logic [NUM_DEV-1:0]        devReadyPulse,
  input  logic [NUM_DEV*PRIO_W-1:0] devPrio,
  input  logic [NUM_DEV*VEC_W-1:0]  devVec,
  input  logic [PRIO_W-1:0]         cpuPrio,
  output logic [NUM_DEV-1:0]        pendMask,
  output logic                      irqOut,
  output logic [VEC_W-1:0]          irqVec,
  output logic [PRIO_W-1:0]         irqPrio
);
  logic [NUM_DEV-1:0] readyQ;
  logic [NUM_DEV-1:0] enableQ;

  // Per-device status flags
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN) begin
        readyQ[d]  <= 1'b0;
        enableQ[d] <= 1'b0;
      end else begin
        if (ctl.write && (regAddr == ADDR_W'(d))) begin
          readyQ[d]  <= regWrData[READY_POS];
          enableQ[d] <= regWrData[EN_POS];
        end
        if (devReadyPulse[d]) readyQ[d] <= 1'b1;
      end
    end
  end

  assign pendMask = readyQ & enableQ;

  // Read mux
  always_comb begin
    regRdData = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (regAddr == ADDR_W'(d)) begin
        regRdData[READY_POS] = readyQ[d];
        regRdData[EN_POS]    = enableQ[d];
      end
    end
  end

  // Priority encoder: highest level wins, lowest index on ties
  logic              winValid;
  logic [PRIO_W-1:0] winPrio;
  logic [VEC_W-1:0]  winVec;
  logic              takeIrq;

  always_comb begin
    winValid = 1'b0;
    winPrio  = '0;
    winVec   = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (pendMask[d] && (!winValid || (devPrio[d*PRIO_W +: PRIO_W] > winPrio))) begin
        winValid = 1'b1;
        winPrio  = devPrio[d*PRIO_W +: PRIO_W];
        winVec   = devVec[d*VEC_W +: VEC_W];
      end
    end
    takeIrq = winValid && (winPrio > cpuPrio);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      irqVec  <= '0;
      irqPrio <= '0;
    end else if (ctl.capture) begin
      irqOut  <= takeIrq;
      irqVec  <= takeIrq ? winVec  : '0;
      irqPrio <= takeIrq ? winPrio : '0;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [STAT_W-1:0]         regWrData,
  output logic [STAT_W-1:0]         regRdData,
  input  logic [NUM_DEV-1:0]        devReadyPulse,
  input  logic [NUM_DEV*PRIO_W-1:0] devPrio,
  input  logic [NUM_DEV*VEC_W-1:0]  devVec,
  input  logic [PRIO_W-1:0]         cpuPrio,
  input  logic                      sampleStb,
  output logic                      irqOut,
  output logic [VEC_W-1:0]          irqVec,
  output logic [PRIO_W-1:0]         irqPrio
);
  ctlStrobes_t        ctl;
  logic [NUM_DEV-1:0] pendMask;

  irq_arb_ctl #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) ctl_i (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .sampleStb(sampleStb),
    .ctl      (ctl)
  );

  irq_arb_dp #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .devReadyPulse(devReadyPulse),
    .devPrio      (devPrio),
    .devVec       (devVec),
    .cpuPrio      (cpuPrio),
    .pendMask     (pendMask),
    .irqOut       (irqOut),
    .irqVec       (irqVec),
    .irqPrio      (irqPrio)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleStb,
  input logic [PRIO_W-1:0]  cpuPrio,
  input logic [NUM_DEV-1:0] pendMask,
  input logic               irqOut,
  input logic [VEC_W-1:0]   irqVec,
  input logic [PRIO_W-1:0]  irqPrio
);
  // R7: outputs hold when no strobe
  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> ($stable(irqOut) && $stable(irqVec) && $stable(irqPrio)));

  // R6: an accepted interrupt is strictly above the program level at the strobe
  p_strict_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> (!irqOut || (irqPrio > $past(cpuPrio))));

  // R8: no interrupt means zero vector and level
  p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> ((irqVec == '0) && (irqPrio == '0)));

  // R4: nothing pending at the strobe means no interrupt
  p_none_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (pendMask == '0)) |=> !irqOut);
endmodule

bind irq_arb irq_arb_chk #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sampleStb(sampleStb),
  .cpuPrio  (cpuPrio),
  .pendMask (pendMask),
  .irqOut   (irqOut),
  .irqVec   (irqVec),
  .irqPrio  (irqPrio)
);

// File: tb/irq_arb_tb_top.sv
`timescale 1ns/1ps
module irq_arb_tb_top;
  localparam int ND = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic [ND-1:0] devReadyPulse = '0;
  logic [ND*3-1:0] devPrio = '0;
  logic [ND*8-1:0] devVec = '0;
  logic [2:0]    cpuPrio = '0;
  logic          sampleStb = 1'b0;
  logic          irqOut;
  logic [7:0]    irqVec;
  logic [2:0]    irqPrio;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_arb #(.NUM_DEV(ND), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .devReadyPulse(devReadyPulse),
    .devPrio(devPrio), .devVec(devVec), .cpuPrio(cpuPrio), .sampleStb(sampleStb),
    .irqOut(irqOut), .irqVec(irqVec), .irqPrio(irqPrio)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int addr, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(addr); regWrData = data;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input int addr, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = AW'(addr);
    #1;
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic strobe();
    @(negedge clk);
    sampleStb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic setCfg(input int cfg);
    for (int d = 0; d < ND; d++) begin
      if (cfg == 0) begin
        devPrio[d*3 +: 3] = 3'((d == 0) ? 2 : (d == 3) ? 0 : 5);
        devVec[d*8 +: 8]  = 8'(8'h80 + d * 3);
      end else begin
        devPrio[d*3 +: 3] = 3'((d == 1) ? 1 : (d == 3) ? 4 : 7);
        devVec[d*8 +: 8]  = 8'(8'h10 + d);
      end
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    #1;
    check(irqOut == 1'b0, "R1 irqOut", irqOut, 0);
    check(irqVec == 8'h0, "R1 irqVec", irqVec, 0);
    check(irqPrio == 3'h0, "R1 irqPrio", irqPrio, 0);
    for (int d = 0; d < ND; d++) rdCheck(d, 16'h0, "R1 status");

    // R9: out-of-range write ignored, read 0
    wrReg(5, 16'hFFFF);
    rdCheck(5, 16'h0, "R9 read out of range");
    for (int d = 0; d < ND; d++) rdCheck(d, 16'h0, "R9 no side effect");

    // R2: only bits 15 and 14 are kept
    wrReg(2, 16'hC0FF);
    rdCheck(2, 16'hC000, "R2 both flags");
    wrReg(2, 16'h4001);
    rdCheck(2, 16'h4000, "R2 enable only");

    // R3: ready pulse, and pulse wins over a clearing write
    @(negedge clk) devReadyPulse = 4'b0010;
    @(negedge clk) devReadyPulse = '0;
    rdCheck(1, 16'h8000, "R3 pulse sets ready");
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3; regWrData = 16'h4000; devReadyPulse = 4'b1000;
    @(negedge clk);
    regWrEn = 1'b0; devReadyPulse = '0;
    rdCheck(3, 16'hC000, "R3 pulse beats write");
    for (int d = 0; d < ND; d++) wrReg(d, 16'h0);

    // R4 R5 R6 R8: exhaustive sweep over flags and program level
    for (int cfg = 0; cfg < 2; cfg++) begin
      setCfg(cfg);
      for (int m = 0; m < 256; m++) begin
        for (int d = 0; d < ND; d++)
          wrReg(d, {m[d], m[4 + d], 14'h0});
        for (int cp = 0; cp < 8; cp++) begin
          int bestP; int bestV; bit found; bit expIrq;
          found = 1'b0; bestP = 0; bestV = 0;
          for (int d = 0; d < ND; d++) begin
            if (m[d] && m[4 + d] && (!found || int'(devPrio[d*3 +: 3]) > bestP)) begin
              found = 1'b1;
              bestP = int'(devPrio[d*3 +: 3]);
              bestV = int'(devVec[d*8 +: 8]);
            end
          end
          expIrq = found && (bestP > cp);
          cpuPrio = 3'(cp);
          strobe();
          check(irqOut == expIrq, "R6 R4 irqOut", irqOut, expIrq);
          check(int'(irqVec) == (expIrq ? bestV : 0), "R5 R8 irqVec", irqVec, expIrq ? bestV : 0);
          check(int'(irqPrio) == (expIrq ? bestP : 0), "R5 R8 irqPrio", irqPrio, expIrq ? bestP : 0);
        end
      end
    end

    // R7: outputs hold between strobes
    setCfg(1);
    for (int d = 0; d < ND; d++) wrReg(d, 16'hC000);
    cpuPrio = 3'd0;
    strobe();
    check(irqOut == 1'b1 && irqVec == 8'h10 && irqPrio == 3'd7, "R7 setup",
          {irqOut, irqVec, irqPrio}, {1'b1, 8'h10, 3'd7});
    cpuPrio = 3'd7;
    for (int d = 0; d < ND; d++) wrReg(d, 16'h0);
    repeat (3) @(negedge clk);
    check(irqOut == 1'b1 && irqVec == 8'h10 && irqPrio == 3'd7, "R7 hold",
          {irqOut, irqVec, irqPrio}, {1'b1, 8'h10, 3'd7});
    strobe();
    check(irqOut == 1'b0 && irqVec == 8'h0 && irqPrio == 3'd0, "R7 update on strobe",
          {irqOut, irqVec, irqPrio}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule